// File: doc/BRIEF.md
# Boundary scan pin segment

This block is a parameterised stretch of a boundary scan data register that sits between the core and a group of pads. It serves a number of bidirectional pins and a number of output-only pins. Each bidirectional pin owns three consecutive scan cells. The first is an enable cell that decides whether the pad driver is on. The second is a data cell for the driven value. The third is an input cell that only watches the pad. An output-only pin owns just the enable cell and the data cell.

A TAP controller outside this block supplies the test clock, the test reset and one-cycle strobes for the capture, shift and update states. It also supplies the decoded instruction levels: external test, clamp and high impedance. Serial data enters at the highest cell index and leaves from cell 0. Outside test modes the core drives the pads and the cells only watch.

Top module: `bscan_pin_segment`

## Requirements
- R1: Cell 0 drives `tdo_o`. On each `tck_i` edge with `shift_dr_i` high, every cell takes the value of the cell one index above it, and the top cell (index L-1) takes `tdi_i`. After L shifts, cell k holds the k-th bit shifted in.
- R2: Bidirectional pin b uses cells 3b (enable), 3b+1 (data) and 3b+2 (input watch). Output-only pin j uses cells 3·NUM_BIDIR+2j (enable) and 3·NUM_BIDIR+2j+1 (data).
- R3: On a `tck_i` edge with `capture_dr_i` high, each enable cell loads the core enable of its pin, each data cell loads the core data of its pin, and each input-watch cell loads `pad_di_i` of its pin. Capture takes priority over shift.
- R4: The update latches of the enable and data cells load the shift stage only on a `tck_i` edge with `update_dr_i` high. While shifting or capturing, the pads driven in test mode do not change.
- R5: With `extest_i` or `clamp_i` high, each pad enable equals its enable-cell latch and each pad data equals its data-cell latch.
- R6: With `extest_i` and `clamp_i` low and `highz_i` low, the pad enables and pad data follow the core enable and core data of the same pin.
- R7: An enable latch holding 0 in test mode turns the pad driver off (pad enable 0), whatever its data latch holds.
- R8: `highz_i` high forces every pad enable to 0 in any mode. Pad data is left unaffected.
- R9: `rst_ni` low clears every shift stage and every update latch to 0 asynchronously. As a result, `tdo_o` reads 0 and, in test mode, all pad drivers are off.
- R10: `core_di_o` always equals `pad_di_i`. The input-watch cells never interfere with the path into the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Test reset, active low, asynchronous |
| tdi_i | input | 1 | Serial data in, enters the top cell |
| capture_dr_i | input | 1 | Capture strobe |
| shift_dr_i | input | 1 | Shift strobe |
| update_dr_i | input | 1 | Update strobe |
| extest_i | input | 1 | External test mode: latches drive the pads |
| clamp_i | input | 1 | Clamp mode: latches drive the pads |
| highz_i | input | 1 | Force all pad drivers off |
| tdo_o | output | 1 | Serial data out from cell 0 |
| core_oe_i | input | NUM_BIDIR | Core enable per bidirectional pin |
| core_do_i | input | NUM_BIDIR | Core data per bidirectional pin |
| core_di_o | output | NUM_BIDIR | Pad input value passed to the core |
| pad_di_i | input | NUM_BIDIR | Value seen on each bidirectional pad |
| pad_oe_o | output | NUM_BIDIR | Driver enable per bidirectional pad |
| pad_do_o | output | NUM_BIDIR | Driven data per bidirectional pad |
| core_oo_oe_i | input | NUM_OUT | Core enable per output-only pin |
| core_oo_do_i | input | NUM_OUT | Core data per output-only pin |
| opad_oe_o | output | NUM_OUT | Driver enable per output-only pad |
| opad_do_o | output | NUM_OUT | Driven data per output-only pad |

## Verification
Random core enables, core data and pad inputs are captured and shifted out. Because every cell gets an independent bit, a swapped triple, a misplaced output-only pin or a reversed shift direction shows up as a mismatch in the serial stream. Random serial words are then updated into the latches under external test and under clamp, with the pads compared before and after the update strobe; this separates a latch that follows the shift stage from one that waits for the update strobe. Directed words with every enable 0 and every data bit 1, the high-impedance request in both modes, and a reset in the middle of test mode cover the driver-off cases.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {CK_EN, CK_DATA, CK_WATCH} cell_kind_e;

  function automatic cell_kind_e kind_of(input int idx, input int nb);
    if (idx < 3 * nb) begin
      case (idx % 3)
        0:       return CK_EN;
        1:       return CK_DATA;
        default: return CK_WATCH;
      endcase
    end
    return ((idx - 3 * nb) % 2 == 0) ? CK_EN : CK_DATA;
  endfunction

  // enable-cell index of pin p (bidir pins first, then output-only)
  function automatic int en_idx(input int p, input int nb);
    return (p < nb) ? 3 * p : 3 * nb + 2 * (p - nb);
  endfunction
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter bit HAS_UPD = 1'b1
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic shift_en_i,
  input  logic upd_en_i,
  input  logic cap_i,
  input  logic ser_i,
  output logic sh_o,
  output logic upd_o
);
  logic sh_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= 1'b0;
    else if (cap_en_i)   sh_q <= cap_i;
    else if (shift_en_i) sh_q <= ser_i;
  end
  assign sh_o = sh_q;

  if (HAS_UPD) begin : g_upd
    logic upd_q;
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)       upd_q <= 1'b0;
      else if (upd_en_i) upd_q <= sh_q;
    end
    assign upd_o = upd_q;

    // R4
    upd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
      !upd_en_i |=> $stable(upd_o));
  end else begin : g_watch
    assign upd_o = 1'b0;
  end

  // R3
  capture_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cap_en_i |=> sh_o == $past(cap_i));
  // R1
  shift_move_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_en_i && !cap_en_i) |=> sh_o == $past(ser_i));
endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux (
  input  logic en_latch_i,
  input  logic do_latch_i,
  input  logic core_oe_i,
  input  logic core_do_i,
  input  logic test_drive_i,
  input  logic force_hz_i,
  output logic pad_oe_o,
  output logic pad_do_o
);
  always_comb begin
    pad_oe_o = test_drive_i ? en_latch_i : core_oe_i;
    pad_do_o = test_drive_i ? do_latch_i : core_do_i;
    if (force_hz_i) pad_oe_o = 1'b0;
  end

  // R6
  always_comb begin
    if (!test_drive_i && !force_hz_i)
      core_path_chk: assert (pad_oe_o == core_oe_i && pad_do_o == core_do_i);
  end
endmodule

// File: rtl/bscan_pin_segment.sv
module bscan_pin_segment #(
  parameter int NUM_BIDIR = 4,
  parameter int NUM_OUT   = 2
) (
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 tdi_i,
  input  logic                 capture_dr_i,
  input  logic                 shift_dr_i,
  input  logic                 update_dr_i,
  input  logic                 extest_i,
  input  logic                 clamp_i,
  input  logic                 highz_i,
  output logic                 tdo_o,
  input  logic [NUM_BIDIR-1:0] core_oe_i,
  input  logic [NUM_BIDIR-1:0] core_do_i,
  output logic [NUM_BIDIR-1:0] core_di_o,
  input  logic [NUM_BIDIR-1:0] pad_di_i,
  output logic [NUM_BIDIR-1:0] pad_oe_o,
  output logic [NUM_BIDIR-1:0] pad_do_o,
  input  logic [NUM_OUT-1:0]   core_oo_oe_i,
  input  logic [NUM_OUT-1:0]   core_oo_do_i,
  output logic [NUM_OUT-1:0]   opad_oe_o,
  output logic [NUM_OUT-1:0]   opad_do_o
);
  import bscan_pkg::*;

  localparam int NUM_PINS  = NUM_BIDIR + NUM_OUT;
  localparam int CHAIN_LEN = 3 * NUM_BIDIR + 2 * NUM_OUT;

  logic [CHAIN_LEN-1:0] cap_w, sh_w, upd_w, ser_w;
  logic [NUM_PINS-1:0]  core_oe_all, core_do_all, oe_all, do_all;
  logic                 test_drive;

  assign test_drive  = extest_i | clamp_i;
  assign core_oe_all = {core_oo_oe_i, core_oe_i};
  assign core_do_all = {core_oo_do_i, core_do_i};
  assign ser_w       = {tdi_i, sh_w[CHAIN_LEN-1:1]};
  assign tdo_o       = sh_w[0];
  assign core_di_o   = pad_di_i;

  // capture sources, laid out per pin
  for (genvar b = 0; b < NUM_BIDIR; b++) begin : g_cap_bidir
    assign cap_w[3*b+2] = pad_di_i[b];
  end
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cap_pin
    localparam int EI = en_idx(p, NUM_BIDIR);
    assign cap_w[EI]   = core_oe_all[p];
    assign cap_w[EI+1] = core_do_all[p];
  end

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    localparam cell_kind_e KIND = kind_of(i, NUM_BIDIR);
    bscan_cell #(.HAS_UPD(KIND != CK_WATCH)) u_cell (
      .tck_i      (tck_i),
      .rst_ni     (rst_ni),
      .cap_en_i   (capture_dr_i),
      .shift_en_i (shift_dr_i),
      .upd_en_i   (update_dr_i),
      .cap_i      (cap_w[i]),
      .ser_i      (ser_w[i]),
      .sh_o       (sh_w[i]),
      .upd_o      (upd_w[i])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    localparam int EI = en_idx(p, NUM_BIDIR);
    bscan_pad_mux u_mux (
      .en_latch_i   (upd_w[EI]),
      .do_latch_i   (upd_w[EI+1]),
      .core_oe_i    (core_oe_all[p]),
      .core_do_i    (core_do_all[p]),
      .test_drive_i (test_drive),
      .force_hz_i   (highz_i),
      .pad_oe_o     (oe_all[p]),
      .pad_do_o     (do_all[p])
    );

    // R5
    latch_drive_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (test_drive && !highz_i) |-> (oe_all[p] == upd_w[EI] && do_all[p] == upd_w[EI+1]));
  end

  assign {opad_oe_o, pad_oe_o} = oe_all;
  assign {opad_do_o, pad_do_o} = do_all;

  // R8
  hz_all_off_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    highz_i |-> (pad_oe_o == '0 && opad_oe_o == '0));
  // R10
  watch_pass_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    core_di_o == pad_di_i);
endmodule

// File: tb/bscan_pin_segment_test.sv
module bscan_pin_segment_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NO = 2;
  localparam int L  = 3 * NB + 2 * NO;

  logic tck = 1'b0, rst_ni = 1'b0, tdi = 1'b0;
  logic cap = 1'b0, sft = 1'b0, upd = 1'b0;
  logic extest = 1'b0, clamp = 1'b0, highz = 1'b0;
  logic tdo;
  logic [NB-1:0] core_oe = '0, core_do = '0, pad_di = '0, core_di, pad_oe, pad_do;
  logic [NO-1:0] oo_oe = '0, oo_do = '0, opad_oe, opad_do;

  int checks = 0, failures = 0;
  logic [L-1:0] held, sv, got, expv;

  always #(CLK_PERIOD/2) tck = ~tck;

  bscan_pin_segment #(.NUM_BIDIR(NB), .NUM_OUT(NO)) uut (
    .tck_i(tck), .rst_ni(rst_ni), .tdi_i(tdi),
    .capture_dr_i(cap), .shift_dr_i(sft), .update_dr_i(upd),
    .extest_i(extest), .clamp_i(clamp), .highz_i(highz), .tdo_o(tdo),
    .core_oe_i(core_oe), .core_do_i(core_do), .core_di_o(core_di), .pad_di_i(pad_di),
    .pad_oe_o(pad_oe), .pad_do_o(pad_do),
    .core_oo_oe_i(oo_oe), .core_oo_do_i(oo_do), .opad_oe_o(opad_oe), .opad_do_o(opad_do));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    @(negedge tck);
  endtask

  // R2 layout: capture image
  function automatic logic [L-1:0] cap_image(input logic [NB-1:0] oe, input logic [NB-1:0] d,
                                             input logic [NB-1:0] di, input logic [NO-1:0] ooe,
                                             input logic [NO-1:0] odo);
    logic [L-1:0] v = '0;
    for (int b = 0; b < NB; b++) begin
      v[3*b] = oe[b]; v[3*b+1] = d[b]; v[3*b+2] = di[b];
    end
    for (int j = 0; j < NO; j++) begin
      v[3*NB+2*j] = ooe[j]; v[3*NB+2*j+1] = odo[j];
    end
    return v;
  endfunction

  function automatic logic [NB+NO-1:0] img_oe(input logic [L-1:0] v);
    logic [NB+NO-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = v[3*b];
    for (int j = 0; j < NO; j++) r[NB+j] = v[3*NB+2*j];
    return r;
  endfunction

  function automatic logic [NB+NO-1:0] img_do(input logic [L-1:0] v);
    logic [NB+NO-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = v[3*b+1];
    for (int j = 0; j < NO; j++) r[NB+j] = v[3*NB+2*j+1];
    return r;
  endfunction

  task automatic chk_pads(input string req, input logic [L-1:0] v);
    chk(req, {opad_oe, pad_oe}, img_oe(v));
    chk(req, {opad_do, pad_do}, img_do(v));
  endtask

  task automatic shift_word(input logic [L-1:0] w, output logic [L-1:0] out);
    for (int k = 0; k < L; k++) begin
      tdi = w[k]; sft = 1'b1;
      out[k] = tdo;
      step();
    end
    sft = 1'b0; tdi = 1'b0;
  endtask

  task automatic pulse_update();
    upd = 1'b1; step(); upd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1149));
    held = '0;
    repeat (3) @(negedge tck);
    extest = 1'b1;
    #1;
    // R9 reset state
    chk("R9", {opad_oe, pad_oe}, '0);
    chk("R9", tdo, 1'b0);
    rst_ni = 1'b1;
    @(negedge tck);
    extest = 1'b0;

    for (int r = 0; r < 24; r++) begin
      core_oe = NB'($urandom); core_do = NB'($urandom); pad_di = NB'($urandom);
      oo_oe = NO'($urandom); oo_do = NO'($urandom);
      #1;
      // R6 / R10 normal mode
      chk("R6", {oo_oe, core_oe}, {opad_oe, pad_oe});
      chk("R6", {oo_do, core_do}, {opad_do, pad_do});
      chk("R10", core_di, pad_di);
      expv = cap_image(core_oe, core_do, pad_di, oo_oe, oo_do);
      cap = 1'b1; step(); cap = 1'b0;
      if (r % 2 == 0) extest = 1'b1; else clamp = 1'b1;
      #1;
      chk("R5", {opad_oe, pad_oe}, img_oe(held));
      sv = L'($urandom);
      if (r == 5) sv = {L{1'b1}};
      shift_word(sv, got);
      // R3 and R1: captured image comes out cell 0 first
      chk("R3", got, expv);
      // R4 pads untouched by shifting
      chk_pads("R4", held);
      pulse_update();
      held = sv;
      // R5 and R2 latch image on pads
      chk_pads("R5", held);
      highz = 1'b1; #1;
      chk("R8", {opad_oe, pad_oe}, '0);
      chk("R8", {opad_do, pad_do}, img_do(held));
      extest = 1'b0; clamp = 1'b0; #1;
      chk("R8", {opad_oe, pad_oe}, '0);
      highz = 1'b0;
    end

    // R7: all enables 0, all data 1
    sv = '0;
    for (int b = 0; b < NB; b++) sv[3*b+1] = 1'b1;
    for (int j = 0; j < NO; j++) sv[3*NB+2*j+1] = 1'b1;
    extest = 1'b1;
    shift_word(sv, got);
    pulse_update();
    chk("R7", {opad_oe, pad_oe}, '0);
    chk("R7", {opad_do, pad_do}, {(NB+NO){1'b1}});

    // R1: single marker walks down to cell 0 after L-1 more shifts
    sv = '0; sv[L-1] = 1'b1;
    shift_word(sv, got);
    chk("R1", tdo, 1'b0);
    sft = 1'b1; tdi = 1'b0;
    for (int k = 0; k < L - 1; k++) step();
    sft = 1'b0;
    chk("R1", tdo, 1'b1);

    // R9: reset in the middle of test mode
    sv = {L{1'b1}};
    shift_word(sv, got);
    pulse_update();
    chk_pads("R5", sv);
    #2 rst_ni = 1'b0; #1;
    chk("R9", {opad_oe, pad_oe}, '0);
    chk("R9", {opad_do, pad_do}, '0);
    chk("R9", tdo, 1'b0);
    @(negedge tck); rst_ni = 1'b1;
    @(negedge tck);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule